// File: doc/BRIEF.md
# Pulse-Interval Frame Receiver and Responder

This block plays the tag side of a low-frequency link that runs both ways. The reader marks its bits by briefly dropping the field. Each such gap shows up here as a rising edge on `gap_in`. The block counts carrier periods, one per `carrier_tick` pulse, from one rising edge to the next. It sorts each interval into a zero bit, a one bit or noise, and packs the accepted bits into an 80-bit frame, first bit at the top.

If no edge arrives for longer than the end-of-frame limit, the frame is closed. A frame holding at least one bit is presented for one cycle on `frame_data` and `frame_bits`. The same carrier counter then keeps running from the last reader edge. It starts a reply at a fixed point, `T_WRESP - T_GAP` periods after that edge. The reply is a start marker of five ones followed by `reply_len` bits taken from `reply_data`. It is sent as Manchester load modulation on `coil_load`. While the reply is pending and being sent, reader edges are not captured.

The block does not interpret frame contents. The payload comes from the surrounding logic.

Top module: `pulse_frame_responder`

## Requirements
- R1: After reset, `frame_valid`, `coil_load` and `reply_busy` are 0.
- R2: An accepted interval of `T0_MIN` up to `T1_MIN - 1` carrier periods is a 0 bit. An interval of `T1_MIN` up to `T_EOF` is a 1 bit. An interval below `T0_MIN` adds no bit.
- R3: The first edge after reset, after a frame end or after a reply adds no bit. It only starts interval timing.
- R4: Bit k of a frame (k = 0 first) is placed at `frame_data[79-k]`. Unfilled positions read 0. `frame_bits` gives the count. Bits after the 80th are dropped.
- R5: The frame ends on the carrier tick that takes the count past `T_EOF` (tick `T_EOF+1` after the last edge). If the frame holds bits, `frame_valid` pulses for exactly one cycle after that tick. A frame with no bits gives no pulse and no reply.
- R6: When an edge and a carrier tick fall in the same cycle, the edge wins. The interval is the count before that cycle. An edge on the tick that would end the frame therefore yields a 1 bit and the frame continues.
- R7: `reply_busy` rises after carrier tick `T_WRESP - T_GAP` (200) counted from the last reader edge, and not before.
- R8: The reply is five 1 bits followed by `min(reply_len, 80)` bits of `reply_data`, starting at bit 79 and going down.
- R9: Each reply bit lasts 31 carrier periods. For a 1, `coil_load` is high for in-bit counts 0–14 and low for 15–30. A 0 is the opposite. `coil_load` is 0 whenever no reply is being sent.
- R10: Edges arriving while a reply is pending or being sent change neither the reply nor the next frame. After the last reply bit, `reply_busy` falls and capture resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_tick | input | 1 | One-cycle pulse per carrier period |
| gap_in | input | 1 | Reader gap detector level; its rising edge marks a bit |
| reply_data | input | 80 | Reply payload, sent from bit 79 downward |
| reply_len | input | 7 | Reply payload bit count, clamped to 80 |
| frame_valid | output | 1 | One-cycle pulse when a frame is closed |
| frame_data | output | 80 | Last received frame, first bit in bit 79 |
| frame_bits | output | 7 | Bit count of the last frame |
| coil_load | output | 1 | Coil load switch for the reply |
| reply_busy | output | 1 | High while reply bits are being sent |

## Verification
Two events can collide in one cycle: a reader edge and a carrier tick. The sharpest case puts the edge on the very tick that would overflow the counter. The bench provokes this by raising `gap_in` and `carrier_tick` together. It does so after 40 counted ticks (the end-of-frame boundary) and also in the middle of an interval. It judges the result from the bits that appear in the delivered frame and from the frame-end timing that follows. These must show an accepted 1 bit with no premature frame end, and a counter restarted from zero without the coincident tick.

// File: rtl/pulse_frame_responder.sv
module pulse_frame_responder #(
  parameter int T0_MIN     = 15,
  parameter int T1_MIN     = 25,
  parameter int T_EOF      = 40,
  parameter int T_WRESP    = 208,
  parameter int T_GAP      = 8,
  parameter int HALF       = 15,
  parameter int BITLEN     = 31,
  parameter int FRAME_BITS = 80,
  parameter int SOF_BITS   = 5
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  carrier_tick,
  input  logic                                  gap_in,
  input  logic [FRAME_BITS-1:0]                 reply_data,
  input  logic [$clog2(FRAME_BITS+1)-1:0]       reply_len,
  output logic                                  frame_valid,
  output logic [FRAME_BITS-1:0]                 frame_data,
  output logic [$clog2(FRAME_BITS+1)-1:0]       frame_bits,
  output logic                                  coil_load,
  output logic                                  reply_busy
);
  localparam int CW  = $clog2(T_WRESP) + 1;
  localparam int NW  = $clog2(FRAME_BITS + 1);
  localparam int RW  = FRAME_BITS + SOF_BITS;
  localparam int RCW = $clog2(RW + 1);
  localparam logic [CW-1:0] C_T0    = CW'(T0_MIN);
  localparam logic [CW-1:0] C_T1    = CW'(T1_MIN);
  localparam logic [CW-1:0] C_EOF   = CW'(T_EOF);
  localparam logic [CW-1:0] C_START = CW'(T_WRESP - T_GAP - 1);
  localparam logic [CW-1:0] C_HALF  = CW'(HALF);
  localparam logic [CW-1:0] C_BEND  = CW'(BITLEN - 1);
  localparam logic [NW-1:0] C_FB    = NW'(FRAME_BITS);
  localparam logic [NW-1:0] C_LAST  = NW'(FRAME_BITS - 1);

  typedef enum logic [1:0] {S_RX, S_WAIT, S_TX} state_t;

  state_t            state;
  logic              gap_q, ovf;
  logic [CW-1:0]     cnt;
  logic [FRAME_BITS-1:0] acc;
  logic [NW-1:0]     nb;
  logic [RW-1:0]     sh;
  logic [RCW-1:0]    left;

  wire rise     = gap_in & ~gap_q;
  wire take     = !ovf && cnt >= C_T0 && cnt <= C_EOF;
  wire bit_val  = cnt >= C_T1;
  wire [NW-1:0] len_c = (reply_len > C_FB) ? C_FB : reply_len;

  assign reply_busy = (state == S_TX);
  assign coil_load  = reply_busy && (sh[RW-1] ? (cnt < C_HALF) : (cnt >= C_HALF));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_RX;
      gap_q       <= 1'b0;
      ovf         <= 1'b1;
      cnt         <= C_EOF + 1'b1;
      acc         <= '0;
      nb          <= '0;
      sh          <= '0;
      left        <= '0;
      frame_valid <= 1'b0;
      frame_data  <= '0;
      frame_bits  <= '0;
    end else begin
      gap_q       <= gap_in;
      frame_valid <= 1'b0;
      case (state)
        S_RX: begin
          if (rise) begin
            cnt <= '0;
            ovf <= 1'b0;
            if (take && nb < C_FB) begin
              acc[C_LAST - nb] <= bit_val;
              nb <= nb + 1'b1;
            end
          end else if (carrier_tick && !ovf) begin
            cnt <= cnt + 1'b1;
            if (cnt == C_EOF) begin
              ovf <= 1'b1;
              if (nb != '0) begin
                frame_valid <= 1'b1;
                frame_data  <= acc;
                frame_bits  <= nb;
                acc         <= '0;
                nb          <= '0;
                state       <= S_WAIT;
              end
            end
          end
        end
        S_WAIT: begin
          if (carrier_tick) begin
            if (cnt == C_START) begin
              cnt   <= '0;
              sh    <= {{SOF_BITS{1'b1}}, reply_data};
              left  <= RCW'(SOF_BITS) + RCW'(len_c);
              state <= S_TX;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          if (carrier_tick) begin
            if (cnt == C_BEND) begin
              cnt  <= '0;
              sh   <= {sh[RW-2:0], 1'b0};
              left <= left - 1'b1;
              if (left == RCW'(1)) begin
                state <= S_RX;
                ovf   <= 1'b1;
                cnt   <= C_EOF + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pulse_frame_responder_chk.sv
module pfr_checker #(
  parameter int FB = 80
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         carrier_tick,
  input logic                         frame_valid,
  input logic [FB-1:0]                frame_data,
  input logic [$clog2(FB+1)-1:0]      frame_bits,
  input logic                         coil_load,
  input logic                         reply_busy
);
  localparam int NW = $clog2(FB + 1);

  AST_NO_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !reply_busy |-> !coil_load); // R9
  AST_COIL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) !carrier_tick |=> $stable(coil_load)); // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) frame_valid |=> !frame_valid); // R5
  AST_BITS_RANGE: assert property (@(posedge clk) disable iff (!rst_n) frame_valid |-> (frame_bits != '0 && frame_bits <= NW'(FB))); // R4
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !frame_valid |-> $stable(frame_data)); // R4
  AST_NO_RX_IN_TX: assert property (@(posedge clk) disable iff (!rst_n) reply_busy |-> !frame_valid); // R10
endmodule

bind pulse_frame_responder pfr_checker #(.FB(FRAME_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .carrier_tick(carrier_tick), .frame_valid(frame_valid),
  .frame_data(frame_data), .frame_bits(frame_bits), .coil_load(coil_load), .reply_busy(reply_busy)
);

// File: tb/sim_pulse_frame_responder.sv
`timescale 1ns/1ps
module sim_pulse_frame_responder;
  localparam int T0 = 15, T1 = 25, TE = 40, START = 200, HB = 15, BL = 31;

  logic        clk = 0, rst_n = 0, carrier_tick = 0, gap_in = 0;
  logic [79:0] reply_data = '0;
  logic [6:0]  reply_len = '0;
  logic        frame_valid, coil_load, reply_busy;
  logic [79:0] frame_data;
  logic [6:0]  frame_bits;

  int checks = 0, fails = 0;
  int iv [0:99];
  bit fv_seen;
  bit finished = 0;

  pulse_frame_responder u0 (
    .clk(clk), .rst_n(rst_n), .carrier_tick(carrier_tick), .gap_in(gap_in),
    .reply_data(reply_data), .reply_len(reply_len), .frame_valid(frame_valid),
    .frame_data(frame_data), .frame_bits(frame_bits), .coil_load(coil_load),
    .reply_busy(reply_busy)
  );

  always #10 clk = ~clk;

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tk();
    carrier_tick = 1;
    @(negedge clk);
    carrier_tick = 0;
    fv_seen = frame_valid;
    @(negedge clk);
  endtask

  task automatic edge_pulse(bit with_tick);
    gap_in = 1;
    carrier_tick = with_tick;
    @(negedge clk);
    gap_in = 0;
    carrier_tick = 0;
    @(negedge clk);
  endtask

  function automatic logic exp_coil(logic b, int m);
    return b ? (m < HB) : (m >= HB);
  endfunction

  // iv[i] >= 1000 : (iv-1000) ticks then edge coinciding with a tick (R6)
  task automatic do_frame(int n, bit inject);
    logic [79:0] ed;
    int en, nrep;
    ed = '0;
    en = 0;
    edge_pulse(0); // R3: start edge, no bit
    for (int i = 0; i < n; i++) begin
      int t;
      t = (iv[i] >= 1000) ? iv[i] - 1000 : iv[i];
      repeat (t) tk();
      edge_pulse(iv[i] >= 1000);
      if (t >= T0 && t <= TE && en < 80) begin
        ed[79-en] = (t >= T1);
        en++;
      end
    end
    for (int t = 1; t <= TE; t++) tk();
    check(fv_seen == 0 && reply_busy == 0, "R5 no early end", {126'd0, fv_seen, reply_busy}, 0);
    tk();
    check(fv_seen == (en > 0), "R5 frame_valid", fv_seen, en > 0);
    if (en == 0) begin
      repeat (START + 20) tk();
      check(reply_busy == 0 && coil_load == 0, "R5 no reply", reply_busy, 0);
      return;
    end
    check(frame_bits == 7'(en), "R4 frame_bits", frame_bits, en);
    check(frame_data == ed, "R2 R4 frame_data", frame_data, ed);
    for (int t = TE + 2; t < START; t++) begin
      tk();
      if (inject && t == 120) edge_pulse(0);
    end
    check(reply_busy == 0, "R7 busy before start", reply_busy, 0);
    tk();
    check(reply_busy == 1, "R7 busy at start", reply_busy, 1);
    nrep = 5 + ((reply_len > 80) ? 80 : int'(reply_len));
    begin
      int bad;
      logic a, e;
      bad = 0; a = 0; e = 0;
      for (int j = 0; j < nrep; j++) begin
        logic b;
        b = (j < 5) ? 1'b1 : reply_data[79-(j-5)];
        for (int m = 0; m < BL; m++) begin
          if (!(j == 0 && m == 0)) tk();
          if (inject && m == 7 && j % 3 == 0) edge_pulse(0); // R10
          if (coil_load !== exp_coil(b, m) && bad == 0) begin
            bad = 1; a = coil_load; e = exp_coil(b, m);
          end
        end
      end
      check(bad == 0, "R8 R9 coil waveform", a, e);
    end
    tk();
    check(reply_busy == 0 && coil_load == 0, "R10 reply done", reply_busy, 0);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      report();
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(frame_valid == 0 && coil_load == 0 && reply_busy == 0, "R1 reset",
          {frame_valid, coil_load, reply_busy}, 0);

    // R2 boundaries
    reply_data = 80'hA5F0_0000_0000_0000_0000; reply_len = 7'd8;
    iv[0] = 14; iv[1] = 15; iv[2] = 24; iv[3] = 25; iv[4] = 40; iv[5] = 10; iv[6] = 30;
    do_frame(7, 0);

    // R6 coincidence: edge on the overflow tick and mid-interval
    reply_data = '0; reply_len = 7'd3;
    iv[0] = 20; iv[1] = 1040; iv[2] = 1018; iv[3] = 1030;
    do_frame(4, 1);

    // R4 more than 80 bits, R8 length clamp
    for (int i = 0; i < 85; i++) iv[i] = (i % 2) ? 30 : 18;
    reply_data = {40'h0123456789, 40'hFEDCBA9876}; reply_len = 7'd100;
    do_frame(85, 0);

    // R5 empty frame
    iv[0] = 5; iv[1] = 12; iv[2] = 3;
    do_frame(3, 0);

    // R8 zero-length payload
    iv[0] = 16; reply_len = 0;
    do_frame(1, 1);

    // random frames
    for (int f = 0; f < 8; f++) begin
      int n;
      n = 1 + ($urandom % 16);
      for (int i = 0; i < n; i++) iv[i] = 10 + ($urandom % 31);
      reply_data = {$urandom, $urandom, 16'($urandom)};
      reply_len = 7'($urandom % 90);
      do_frame(n, f[0]);
    end
    finished = 1;
    report();
  end
endmodule